// File: doc/BRIEF.md
# Prefix-Escape Byte Instruction Decoder

This block turns a stream of one-byte instruction codes for an eight-register machine into resolved micro-operations. The default byte is a two-operand register move. Escape bytes placed ahead of a move change what it does: an ALU-function escape turns the move into an arithmetic or logic operation, and a register escape adds a third operand register together with an extension field that widens the register range. The decoder keeps these escapes as hidden pending state and, when the move byte arrives, issues one micro-operation that merges all of them. The pending state is then dropped.

Pending escape state cannot be saved anywhere. For that reason the decoder raises an interrupt-inhibit output whenever an escape is outstanding, so that the escape-plus-move group runs as one atomic unit. Reserved byte codes are reported as illegal and discard any pending escapes. A repeated escape of the same kind overrides the earlier one and is flagged. A synchronous reset or a flush input empties the pending state at once.

Top module: `pfx_decoder`

## Requirements
- R1: A move byte `00-sss-ddd` with no pending escape produces, in the cycle after it is accepted, a one-cycle `uop_valid` with `uop_alu`=0, `uop_third_valid`=0, `uop_src`=sss (bits 5:3) and `uop_dst`=ddd (bits 2:0).
- R2: A common-function escape `01-000-aaa` followed by a move yields a micro-op with `uop_alu`=1, `uop_rare`=0 and `uop_func`=aaa (bits 2:0).
- R3: A rare-function escape `01-001-bbb` followed by a move yields a micro-op with `uop_alu`=1, `uop_rare`=1 and `uop_func`=bbb.
- R4: A register escape `10-ppp-rrr` followed by a move yields `uop_third_valid`=1, `uop_third`=rrr (bits 2:0) and `uop_ext`=ppp (bits 5:3).
- R5: One ALU escape and one register escape, in either order, combine into a single micro-op carrying both.
- R6: `irq_inhibit` is 1 in the cycle after an escape is accepted, stays 1 while escapes are pending, and is 0 in the cycle after the move that consumes them.
- R7: A second escape of the same kind before the move replaces the first. The common and rare ALU escapes count as one kind. `dup_prefix` pulses for one cycle after the second escape is accepted.
- R8: Bytes `11-xxx-xxx` and `01-mmm-xxx` with mmm ≥ 2 pulse `illegal` for one cycle, emit no micro-op, clear pending escapes and drop `irq_inhibit`.
- R9: Reset or `flush` clears pending escapes, so `irq_inhibit` is 0 in the following cycle and the next move decodes as a plain move. After reset every output is 0.
- R10: Cycles with `in_valid`=0 change no pending state and emit nothing.
- R11: Escape bytes never produce `uop_valid`. Each accepted move produces exactly one micro-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Synchronous discard of pending escapes; any byte offered in that cycle is dropped |
| in_valid | input | 1 | Byte on `in_byte` is offered this cycle |
| in_byte | input | 2*REG_W+2 | Instruction byte |
| uop_valid | output | 1 | Micro-op present for one cycle |
| uop_alu | output | 1 | Operation is an ALU function, not a move |
| uop_rare | output | 1 | ALU function comes from the rare set |
| uop_func | output | REG_W | ALU function code |
| uop_src | output | REG_W | Source register |
| uop_dst | output | REG_W | Destination register |
| uop_third_valid | output | 1 | Third operand present |
| uop_third | output | REG_W | Third operand register |
| uop_ext | output | REG_W | Register-range extension field |
| dup_prefix | output | 1 | Pulse: a same-kind escape overrode an earlier one |
| illegal | output | 1 | Pulse: reserved byte received |
| irq_inhibit | output | 1 | Escapes pending; interrupts must wait |

## Verification
Every result is registered, so the micro-op, `dup_prefix`, `illegal` and the new level of `irq_inhibit` are all due one clock after the edge that captures the byte or the flush. The bench drives each byte just after a falling edge and samples 1 ns after the next rising edge, when those registered values have settled. A second sample one cycle later confirms that the pulses have returned to 0. Idle cycles between escape and move show that the pending state and the inhibit level are held.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
   // Classification of one instruction byte
   typedef enum logic [2:0] {
      BK_MOVE,
      BK_ALU_COM,
      BK_ALU_RARE,
      BK_REGX,
      BK_RSVD
   } byte_kind_e;
endpackage

// File: rtl/pfx_classify.sv
module pfx_classify #(
   parameter int REG_W = 3
) (
   input  logic [2*REG_W+1:0]      byte_i,
   output pfx_pkg::byte_kind_e     kind_o,
   output logic [REG_W-1:0]        mid_o,
   output logic [REG_W-1:0]        low_o
);
   import pfx_pkg::*;
   localparam int BYTE_W = 2*REG_W + 2;

   logic [1:0] top;
   assign top   = byte_i[BYTE_W-1 -: 2];
   assign mid_o = byte_i[2*REG_W-1 -: REG_W];
   assign low_o = byte_i[REG_W-1:0];

   always_comb begin
      unique case (top)
         2'b00: kind_o = BK_MOVE;
         2'b10: kind_o = BK_REGX;
         2'b11: kind_o = BK_RSVD;
         default: begin
            if (mid_o == REG_W'(0))      kind_o = BK_ALU_COM;
            else if (mid_o == REG_W'(1)) kind_o = BK_ALU_RARE;
            else                         kind_o = BK_RSVD;
         end
      endcase
   end
endmodule

// File: rtl/pfx_state.sv
module pfx_state #(
   parameter int REG_W = 3
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                flush,
   input  logic                valid_i,
   input  pfx_pkg::byte_kind_e kind_i,
   input  logic [REG_W-1:0]    mid_i,
   input  logic [REG_W-1:0]    low_i,
   output logic                alu_pend_o,
   output logic                alu_rare_o,
   output logic [REG_W-1:0]    alu_func_o,
   output logic                rx_pend_o,
   output logic [REG_W-1:0]    rx_ext_o,
   output logic [REG_W-1:0]    rx_reg_o,
   output logic                dup_o,
   output logic                inhibit_o
);
   import pfx_pkg::*;

   logic take;
   assign take = valid_i && !flush;

   always_ff @(posedge clk) begin
      if (rst || flush) begin
         alu_pend_o <= 1'b0;
         alu_rare_o <= 1'b0;
         alu_func_o <= '0;
         rx_pend_o  <= 1'b0;
         rx_ext_o   <= '0;
         rx_reg_o   <= '0;
         dup_o      <= 1'b0;
      end else if (take) begin
         dup_o <= 1'b0;
         unique case (kind_i)
            BK_ALU_COM, BK_ALU_RARE: begin
               alu_pend_o <= 1'b1;
               alu_rare_o <= (kind_i == BK_ALU_RARE);
               alu_func_o <= low_i;
               dup_o      <= alu_pend_o;
            end
            BK_REGX: begin
               rx_pend_o <= 1'b1;
               rx_ext_o  <= mid_i;
               rx_reg_o  <= low_i;
               dup_o     <= rx_pend_o;
            end
            default: begin
               alu_pend_o <= 1'b0;
               alu_rare_o <= 1'b0;
               alu_func_o <= '0;
               rx_pend_o  <= 1'b0;
               rx_ext_o   <= '0;
               rx_reg_o   <= '0;
            end
         endcase
      end else begin
         dup_o <= 1'b0;
      end
   end

   assign inhibit_o = alu_pend_o || rx_pend_o;

   // R7
   dup_on_repeat_chk: assert property (@(posedge clk) disable iff (rst)
      (take && (kind_i == BK_ALU_COM || kind_i == BK_ALU_RARE) && alu_pend_o) |=> dup_o);

   // R10
   idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
      (!valid_i && !flush) |=> ($stable(inhibit_o) && !dup_o));
endmodule

// File: rtl/pfx_emit.sv
module pfx_emit #(
   parameter int REG_W   = 3,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                flush,
   input  logic                valid_i,
   input  pfx_pkg::byte_kind_e kind_i,
   input  logic [REG_W-1:0]    mid_i,
   input  logic [REG_W-1:0]    low_i,
   input  logic                alu_pend_i,
   input  logic                alu_rare_i,
   input  logic [REG_W-1:0]    alu_func_i,
   input  logic                rx_pend_i,
   input  logic [REG_W-1:0]    rx_ext_i,
   input  logic [REG_W-1:0]    rx_reg_i,
   output logic                uop_valid_o,
   output logic                uop_alu_o,
   output logic                uop_rare_o,
   output logic [REG_W-1:0]    uop_func_o,
   output logic [REG_W-1:0]    uop_src_o,
   output logic [REG_W-1:0]    uop_dst_o,
   output logic                uop_third_valid_o,
   output logic [REG_W-1:0]    uop_third_o,
   output logic [REG_W-1:0]    uop_ext_o,
   output logic                illegal_o
);
   import pfx_pkg::*;

   logic             fire, bad;
   logic             n_alu, n_rare, n_tv;
   logic [REG_W-1:0] n_func, n_src, n_dst, n_third, n_ext;

   always_comb begin
      fire    = valid_i && !flush && (kind_i == BK_MOVE);
      bad     = valid_i && !flush && (kind_i == BK_RSVD);
      n_alu   = fire && alu_pend_i;
      n_rare  = fire && alu_pend_i && alu_rare_i;
      n_func  = (fire && alu_pend_i) ? alu_func_i : '0;
      n_src   = fire ? mid_i : '0;
      n_dst   = fire ? low_i : '0;
      n_tv    = fire && rx_pend_i;
      n_third = (fire && rx_pend_i) ? rx_reg_i : '0;
      n_ext   = (fire && rx_pend_i) ? rx_ext_i : '0;
   end

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (rst) begin
               uop_valid_o       <= 1'b0;
               uop_alu_o         <= 1'b0;
               uop_rare_o        <= 1'b0;
               uop_func_o        <= '0;
               uop_src_o         <= '0;
               uop_dst_o         <= '0;
               uop_third_valid_o <= 1'b0;
               uop_third_o       <= '0;
               uop_ext_o         <= '0;
               illegal_o         <= 1'b0;
            end else begin
               uop_valid_o       <= fire;
               uop_alu_o         <= n_alu;
               uop_rare_o        <= n_rare;
               uop_func_o        <= n_func;
               uop_src_o         <= n_src;
               uop_dst_o         <= n_dst;
               uop_third_valid_o <= n_tv;
               uop_third_o       <= n_third;
               uop_ext_o         <= n_ext;
               illegal_o         <= bad;
            end
         end
      end else begin : g_comb
         assign uop_valid_o       = fire && !rst;
         assign uop_alu_o         = n_alu;
         assign uop_rare_o        = n_rare;
         assign uop_func_o        = n_func;
         assign uop_src_o         = n_src;
         assign uop_dst_o         = n_dst;
         assign uop_third_valid_o = n_tv;
         assign uop_third_o       = n_third;
         assign uop_ext_o         = n_ext;
         assign illegal_o         = bad && !rst;
      end
   endgenerate
endmodule

// File: rtl/pfx_decoder.sv
module pfx_decoder #(
   parameter int REG_W   = 3,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 flush,
   input  logic                 in_valid,
   input  logic [2*REG_W+1:0]   in_byte,
   output logic                 uop_valid,
   output logic                 uop_alu,
   output logic                 uop_rare,
   output logic [REG_W-1:0]     uop_func,
   output logic [REG_W-1:0]     uop_src,
   output logic [REG_W-1:0]     uop_dst,
   output logic                 uop_third_valid,
   output logic [REG_W-1:0]     uop_third,
   output logic [REG_W-1:0]     uop_ext,
   output logic                 dup_prefix,
   output logic                 illegal,
   output logic                 irq_inhibit
);
   import pfx_pkg::*;

   generate
      if (REG_W < 2 || REG_W > 6) begin : g_bad_width
         $error("pfx_decoder: REG_W must lie in 2..6");
      end
   endgenerate

   byte_kind_e       kind;
   logic [REG_W-1:0] mid, low;
   logic             alu_pend, alu_rare, rx_pend;
   logic [REG_W-1:0] alu_func, rx_ext, rx_reg;

   pfx_classify #(.REG_W(REG_W)) u_cls (
      .byte_i (in_byte),
      .kind_o (kind),
      .mid_o  (mid),
      .low_o  (low)
   );

   pfx_state #(.REG_W(REG_W)) u_st (
      .clk        (clk),
      .rst        (rst),
      .flush      (flush),
      .valid_i    (in_valid),
      .kind_i     (kind),
      .mid_i      (mid),
      .low_i      (low),
      .alu_pend_o (alu_pend),
      .alu_rare_o (alu_rare),
      .alu_func_o (alu_func),
      .rx_pend_o  (rx_pend),
      .rx_ext_o   (rx_ext),
      .rx_reg_o   (rx_reg),
      .dup_o      (dup_prefix),
      .inhibit_o  (irq_inhibit)
   );

   pfx_emit #(.REG_W(REG_W), .OUT_REG(OUT_REG)) u_em (
      .clk               (clk),
      .rst               (rst),
      .flush             (flush),
      .valid_i           (in_valid),
      .kind_i            (kind),
      .mid_i             (mid),
      .low_i             (low),
      .alu_pend_i        (alu_pend),
      .alu_rare_i        (alu_rare),
      .alu_func_i        (alu_func),
      .rx_pend_i         (rx_pend),
      .rx_ext_i          (rx_ext),
      .rx_reg_i          (rx_reg),
      .uop_valid_o       (uop_valid),
      .uop_alu_o         (uop_alu),
      .uop_rare_o        (uop_rare),
      .uop_func_o        (uop_func),
      .uop_src_o         (uop_src),
      .uop_dst_o         (uop_dst),
      .uop_third_valid_o (uop_third_valid),
      .uop_third_o       (uop_third),
      .uop_ext_o         (uop_ext),
      .illegal_o         (illegal)
   );

   logic is_pfx;
   assign is_pfx = (kind == BK_ALU_COM) || (kind == BK_ALU_RARE) || (kind == BK_REGX);

   // R6
   inhibit_after_prefix_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !flush && is_pfx) |=> irq_inhibit);

   // R6
   inhibit_drop_on_move_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !flush && kind == BK_MOVE) |=> !irq_inhibit);

   // R9
   flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
      flush |=> (!irq_inhibit && !uop_valid && !illegal));

   // R8
   reserved_flags_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !flush && kind == BK_RSVD) |=> (illegal && !uop_valid && !irq_inhibit));

   // R11
   uop_only_from_move_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !flush && is_pfx) |=> !uop_valid);
endmodule

// File: tb/pfx_decoder_tb.sv
`timescale 1ns/1ps
module pfx_decoder_tb;
   localparam int REG_W = 3;

   logic clk = 1'b0;
   logic rst, flush, in_valid;
   logic [7:0] in_byte;
   logic uop_valid, uop_alu, uop_rare, uop_third_valid, dup_prefix, illegal, irq_inhibit;
   logic [2:0] uop_func, uop_src, uop_dst, uop_third, uop_ext;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   pfx_decoder #(.REG_W(REG_W)) u_dut (
      .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid), .in_byte(in_byte),
      .uop_valid(uop_valid), .uop_alu(uop_alu), .uop_rare(uop_rare), .uop_func(uop_func),
      .uop_src(uop_src), .uop_dst(uop_dst), .uop_third_valid(uop_third_valid),
      .uop_third(uop_third), .uop_ext(uop_ext), .dup_prefix(dup_prefix),
      .illegal(illegal), .irq_inhibit(irq_inhibit)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One byte accepted at the next rising edge; returns 1 ns after it
   task automatic push(input logic [7:0] b);
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = b;
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   task automatic idle();
      @(posedge clk);
      #1;
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(posedge clk);
      #1;
      flush = 1'b0;
   endtask

   // Checks a micro-op sampled right after the move edge
   task automatic chk_uop(input string req, input int alu, input int rare, input int func,
                          input int src, input int dst, input int tv, input int third, input int ext);
      chk({req, " uop_valid"}, uop_valid, 1);
      chk({req, " alu"}, uop_alu, alu);
      chk({req, " rare"}, uop_rare, rare);
      chk({req, " func"}, uop_func, func);
      chk({req, " src"}, uop_src, src);
      chk({req, " dst"}, uop_dst, dst);
      chk({req, " third_valid"}, uop_third_valid, tv);
      chk({req, " third"}, uop_third, third);
      chk({req, " ext"}, uop_ext, ext);
      chk({req, " inhibit after move"}, irq_inhibit, 0);
   endtask

   task automatic t_reset();
      chk("R9 reset uop_valid", uop_valid, 0);
      chk("R9 reset inhibit", irq_inhibit, 0);
      chk("R9 reset illegal", illegal, 0);
      chk("R9 reset dup", dup_prefix, 0);
   endtask

   task automatic t_plain_move(); // R1
      push(8'h2B);
      chk_uop("R1", 0, 0, 0, 5, 3, 0, 0, 0);
      idle();
      chk("R1 pulse ends", uop_valid, 0);
   endtask

   task automatic t_common(); // R2 R6 R11
      push(8'h46);
      chk("R11 no uop on prefix", uop_valid, 0);
      chk("R6 inhibit after prefix", irq_inhibit, 1);
      push(8'h17);
      chk_uop("R2", 1, 0, 6, 2, 7, 0, 0, 0);
   endtask

   task automatic t_rare(); // R3
      push(8'h4B);
      push(8'h00);
      chk_uop("R3", 1, 1, 3, 0, 0, 0, 0, 0);
   endtask

   task automatic t_regx(); // R4
      push(8'hAC);
      chk("R6 inhibit after reg prefix", irq_inhibit, 1);
      push(8'h3F);
      chk_uop("R4", 0, 0, 0, 7, 7, 1, 4, 5);
   endtask

   task automatic t_combine(); // R5
      push(8'h81);
      push(8'h42);
      chk("R5 no dup for distinct kinds", dup_prefix, 0);
      push(8'h08);
      chk_uop("R5", 1, 0, 2, 1, 0, 1, 1, 0);
   endtask

   task automatic t_dup(); // R7
      push(8'h41);
      chk("R7 no dup first", dup_prefix, 0);
      push(8'h4D);
      chk("R7 dup alu", dup_prefix, 1);
      push(8'h11);
      chk("R7 dup pulse ends", dup_prefix, 0);
      chk_uop("R7 alu replace", 1, 1, 5, 2, 1, 0, 0, 0);
      push(8'h91);
      push(8'h9E);
      chk("R7 dup regx", dup_prefix, 1);
      push(8'h09);
      chk_uop("R7 regx replace", 0, 0, 0, 1, 1, 1, 6, 3);
   endtask

   task automatic t_illegal(); // R8
      push(8'h46);
      push(8'hC0);
      chk("R8 illegal 11", illegal, 1);
      chk("R8 no uop", uop_valid, 0);
      chk("R8 inhibit cleared", irq_inhibit, 0);
      push(8'h2B);
      chk("R8 illegal pulse ends", illegal, 0);
      chk_uop("R8 prefix discarded", 0, 0, 0, 5, 3, 0, 0, 0);
      push(8'hA1);
      push(8'h52);
      chk("R8 illegal 01-010", illegal, 1);
      chk("R8 inhibit cleared 2", irq_inhibit, 0);
      push(8'h2B);
      chk_uop("R8 regx discarded", 0, 0, 0, 5, 3, 0, 0, 0);
   endtask

   task automatic t_flush(); // R9
      push(8'h46);
      push(8'h93);
      do_flush();
      chk("R9 flush inhibit", irq_inhibit, 0);
      chk("R9 flush no uop", uop_valid, 0);
      push(8'h2B);
      chk_uop("R9 after flush", 0, 0, 0, 5, 3, 0, 0, 0);
   endtask

   task automatic t_idle(); // R10
      push(8'h4A);
      for (int i = 0; i < 5; i++) begin
         idle();
         chk("R10 idle no uop", uop_valid, 0);
         chk("R10 idle inhibit", irq_inhibit, 1);
      end
      push(8'h1A);
      chk_uop("R10 held prefix", 1, 1, 2, 3, 2, 0, 0, 0);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; flush = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      rst = 1'b0;
      t_plain_move();
      t_common();
      t_rare();
      t_regx();
      t_combine();
      t_dup();
      t_illegal();
      t_flush();
      t_idle();
      idle();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule